// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block forms the second operand of a 32-bit data-processing instruction. From the low twelve bits of the instruction word, an immediate-select bit, the value of the source register, the low byte of the shift-amount register and the current carry flag, it produces a 32-bit operand and the carry that the shifter passes on to the flag logic.

There are three operand forms. The first is an 8-bit constant rotated right by an even amount. The second is a register shifted by a 5-bit constant. The third is a register shifted by an amount held in another register. All four shift kinds are covered, as are the encodings where an amount of zero or an amount of 32 or more has a special meaning. The result is computed combinationally. It is captured in an output register when the input strobe is high, so each result appears one clock after its request.

Top module: `operand_shifter`

## Requirements
- R1: With `imm_sel` high, `op2` equals `field[7:0]` rotated right by twice `field[11:8]` (rotate field 0xF with byte 0x01 gives 0x00000004).
- R2: With `imm_sel` high, `carry_out` equals bit 31 of the rotated value when `field[11:8]` is nonzero, and equals `carry_in` when it is zero.
- R3: With `imm_sel` low, `field[4]`=0 and `field[6:5]`=00 (LSL), a nonzero amount n=`field[11:7]` gives `rm_val` shifted left by n with carry equal to `rm_val` bit 32−n; an amount of 0 passes `rm_val` and `carry_in` through.
- R4: With `field[4]`=0 and `field[6:5]`=01 (LSR), a nonzero n gives a logical right shift with carry equal to bit n−1; an amount of 0 means a shift by 32 (result 0, carry equal to bit 31).
- R5: With `field[6:5]`=10 (ASR), vacated bits take the sign bit and the carry is bit n−1; an immediate amount of 0 means a shift by 32 (all copies of bit 31, carry equal to bit 31).
- R6: With `field[4]`=0 and `field[6:5]`=11 (ROR), a nonzero n rotates right with carry equal to bit n−1; an amount of 0 selects rotate-through-carry: `carry_in` enters bit 31, the rest shifts right by one, and bit 0 becomes the carry.
- R7: With `field[4]`=1 (amount taken from `rs_byte`) and `rs_byte`=0, every shift kind passes `rm_val` and `carry_in` through unchanged.
- R8: With `field[4]`=1, LSL or LSR by exactly 32 gives 0 with carry equal to bit 0 (LSL) or bit 31 (LSR); amounts above 32 give 0 with carry 0; amounts 1 to 31 follow R3 and R4.
- R9: With `field[4]`=1, ASR by 32 or more gives 32 copies of bit 31 with carry equal to bit 31.
- R10: With `field[4]`=1, ROR uses `rs_byte` modulo 32; a nonzero multiple of 32 leaves the value unchanged with carry equal to bit 31.
- R11: `op2` and `carry_out` are loaded only on a clock edge where `in_valid` is high. `out_valid` is high in the cycle after such an edge and low otherwise, and the outputs hold while `in_valid` is low.
- R12: While `rst` is high, the next edge clears `out_valid`, `op2` and `carry_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; loads the output register |
| imm_sel | input | 1 | 1: rotated immediate form, 0: shifted register form |
| field | input | 12 | Low twelve bits of the instruction word |
| rm_val | input | 32 | Value of the register being shifted |
| rs_byte | input | 8 | Low byte of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered result is new this cycle |
| op2 | output | 32 | Registered shifted operand |
| carry_out | output | 1 | Registered shifter carry-out |

## Verification
The assertions assume that every input is a known value on any edge where `in_valid` is high. They also assume that `rst` is held for at least one edge before the first request. The assertions check only what is captured one edge after a request, so they do not depend on the inputs while the strobe is low. The stimulus changes inputs only at falling edges, keeps `rst` high for several edges at start-up, and fills every field with a defined value whenever it raises `in_valid`. Unused bits of `field`, such as the register index in bits 3:0, are held at zero.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

    localparam int OP_W   = 32;                 // operand width
    localparam int AMT_W  = $clog2(OP_W) + 1;   // holds 0..OP_W
    localparam int IMM_W  = 8;                  // immediate byte
    localparam int ROT_W  = 4;                  // rotate field
    localparam int RSB_W  = 8;                  // register amount byte
    localparam int FLD_W  = 12;                 // operand field width
    localparam int SHF_W  = 5;                  // immediate shift amount

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic [2:0] {
        PL_PASS,    // value and carry unchanged
        PL_SHIFT,   // use the lane for kind, amount 1..OP_W
        PL_RRX,     // rotate one through carry
        PL_CLEAR,   // zero result, zero carry
        PL_WRAP     // value unchanged, carry = msb
    } plan_mode_e;

    typedef struct packed {
        shift_kind_e             kind;
        plan_mode_e              mode;
        logic [AMT_W-1:0]        amt;
    } shift_plan_t;

    typedef struct packed {
        logic [OP_W-1:0] value;
        logic            carry;
    } operand_t;

    function automatic logic [OP_W-1:0] f_ror(input logic [OP_W-1:0] v,
                                             input logic [AMT_W-1:0] n);
        logic [AMT_W-1:0] back;
        back = AMT_W'(OP_W) - n;
        return (v >> n) | (v << back);
    endfunction

endpackage

// File: rtl/opsh_immrot.sv
module opsh_immrot
    import opsh_pkg::*;
(
    input  logic [FLD_W-1:0] field,
    input  logic             carry_in,
    output operand_t         res
);
    logic [AMT_W-1:0] rot_amt;
    logic [OP_W-1:0]  rotated;

    always_comb begin
        rot_amt = AMT_W'({field[IMM_W +: ROT_W], 1'b0});
        rotated = f_ror(OP_W'(field[IMM_W-1:0]), rot_amt);
        res.value = rotated;
        res.carry = (rot_amt == '0) ? carry_in : rotated[OP_W-1];
    end
endmodule

// File: rtl/opsh_plan.sv
module opsh_plan
    import opsh_pkg::*;
(
    input  logic [FLD_W-1:4] sfield,   // bits 11:4 of the operand field
    input  logic [RSB_W-1:0] rs_byte,
    output shift_plan_t      plan
);
    logic [SHF_W-1:0] imm_amt;
    logic             by_reg;
    shift_kind_e      kind;

    always_comb begin
        imm_amt   = sfield[FLD_W-1:7];
        by_reg    = sfield[4];
        kind      = shift_kind_e'(sfield[6:5]);
        plan.kind = kind;
        plan.mode = PL_SHIFT;
        plan.amt  = AMT_W'(imm_amt);

        if (!by_reg) begin
            if (imm_amt == '0) begin
                unique case (kind)
                    SH_LSL: plan.mode = PL_PASS;
                    SH_LSR,
                    SH_ASR: plan.amt  = AMT_W'(OP_W);
                    SH_ROR: plan.mode = PL_RRX;
                    default: plan.mode = PL_PASS;
                endcase
            end
        end else begin
            plan.amt = AMT_W'(rs_byte[AMT_W-2:0]);
            if (rs_byte == '0) begin
                plan.mode = PL_PASS;
            end else begin
                unique case (kind)
                    SH_LSL,
                    SH_LSR: begin
                        if (rs_byte == RSB_W'(OP_W))
                            plan.amt = AMT_W'(OP_W);
                        else if (rs_byte > RSB_W'(OP_W))
                            plan.mode = PL_CLEAR;
                    end
                    SH_ASR: begin
                        if (rs_byte >= RSB_W'(OP_W))
                            plan.amt = AMT_W'(OP_W);
                    end
                    SH_ROR: begin
                        if (rs_byte[AMT_W-2:0] == '0)
                            plan.mode = PL_WRAP;
                    end
                    default: plan.mode = PL_PASS;
                endcase
            end
        end
    end
endmodule

// File: rtl/opsh_lane.sv
module opsh_lane
    import opsh_pkg::*;
#(
    parameter int KIND = 0
)(
    input  logic [OP_W-1:0]  val,
    input  logic [AMT_W-1:0] amt,     // 1..OP_W when selected
    output operand_t         res
);
    generate
        if (KIND == int'(SH_LSL)) begin : g_lsl
            logic [OP_W:0] ext;
            always_comb begin
                ext       = {1'b0, val} << amt;
                res.value = ext[OP_W-1:0];
                res.carry = ext[OP_W];
            end
        end else if (KIND == int'(SH_LSR)) begin : g_lsr
            logic [OP_W:0] ext;
            always_comb begin
                ext       = {val, 1'b0} >> amt;
                res.value = ext[OP_W:1];
                res.carry = ext[0];
            end
        end else if (KIND == int'(SH_ASR)) begin : g_asr
            logic signed [OP_W:0] sx;
            logic signed [OP_W:0] ext;
            always_comb begin
                sx        = {val, 1'b0};
                ext       = sx >>> amt;
                res.value = ext[OP_W:1];
                res.carry = ext[0];
            end
        end else begin : g_ror
            logic [OP_W-1:0] r;
            always_comb begin
                r         = f_ror(val, amt);
                res.value = r;
                res.carry = r[OP_W-1];
            end
        end
    endgenerate
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
    import opsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              imm_sel,
    input  logic [11:0]       field,
    input  logic [31:0]       rm_val,
    input  logic [7:0]        rs_byte,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [31:0]       op2,
    output logic              carry_out
);
    localparam int N_KIND = 4;

    operand_t    imm_res;
    operand_t    sh_res;
    operand_t    next_res;
    shift_plan_t plan;
    operand_t    lane_res [N_KIND];

    opsh_immrot u_immrot (
        .field    (field),
        .carry_in (carry_in),
        .res      (imm_res)
    );

    opsh_plan u_plan (
        .sfield  (field[FLD_W-1:4]),
        .rs_byte (rs_byte),
        .plan    (plan)
    );

    generate
        for (genvar k = 0; k < N_KIND; k++) begin : g_lane
            opsh_lane #(.KIND(k)) u_lane (
                .val (rm_val),
                .amt (plan.amt),
                .res (lane_res[k])
            );
        end
    endgenerate

    always_comb begin
        unique case (plan.mode)
            PL_PASS:  sh_res = '{value: rm_val, carry: carry_in};
            PL_SHIFT: sh_res = lane_res[plan.kind];
            PL_RRX:   sh_res = '{value: {carry_in, rm_val[OP_W-1:1]}, carry: rm_val[0]};
            PL_CLEAR: sh_res = '{value: '0, carry: 1'b0};
            PL_WRAP:  sh_res = '{value: rm_val, carry: rm_val[OP_W-1]};
            default:  sh_res = '{value: rm_val, carry: carry_in};
        endcase
        next_res = imm_sel ? imm_res : sh_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            op2       <= '0;
            carry_out <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                op2       <= next_res.value;
                carry_out <= next_res.carry;
            end
        end
    end

    // R12: reset clears the output stage
    a_r12_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && op2 == '0 && !carry_out));

    // R11: strobe produces out_valid one cycle later
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R11: no strobe, outputs hold and valid drops
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(op2) && $stable(carry_out)));

    // R2: immediate with zero rotation keeps the carry and the raw byte
    a_r2_zero_rot: assert property (@(posedge clk) disable iff (rst)
        (in_valid && imm_sel && field[11:8] == 4'h0) |=>
        (op2 == {24'h0, $past(field[7:0])} && carry_out == $past(carry_in)));

    // R6: rotate-through-carry form
    a_r6_rrx: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !imm_sel && !field[4] && field[6:5] == 2'b11 && field[11:7] == 5'd0) |=>
        (op2 == {$past(carry_in), $past(rm_val[31:1])} && carry_out == $past(rm_val[0])));

    // R7: register amount of zero is a pass-through
    a_r7_reg_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !imm_sel && field[4] && rs_byte == 8'd0) |=>
        (op2 == $past(rm_val) && carry_out == $past(carry_in)));

    // R8: logical shifts by more than the width clear everything
    a_r8_over_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !imm_sel && field[4] && !field[6] && rs_byte > 8'd32) |=>
        (op2 == 32'h0 && !carry_out));

    // R9: large arithmetic shift replicates the sign into result and carry
    a_r9_asr_fill: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !imm_sel && field[4] && field[6:5] == 2'b10 && rs_byte >= 8'd32) |=>
        (op2 == {32{$past(rm_val[31])}} && carry_out == $past(rm_val[31])));

endmodule

// File: tb/sim_operand_shifter.sv
module sim_operand_shifter;

    typedef struct packed {
        logic        imm;
        logic [11:0] ins;
        logic [31:0] rm;
        logic [7:0]  rs;
        logic        ci;
        logic [31:0] eo;
        logic        ec;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VT [NV] = '{
        '{1'b1, 12'hF01, 32'h0,        8'd0,   1'b0, 32'h00000004, 1'b0, 4'd1},  // R1
        '{1'b1, 12'h101, 32'h0,        8'd0,   1'b1, 32'h40000000, 1'b0, 4'd1},  // R1
        '{1'b1, 12'h4FF, 32'h0,        8'd0,   1'b0, 32'hFF000000, 1'b1, 4'd2},  // R2
        '{1'b1, 12'h0AB, 32'h0,        8'd0,   1'b1, 32'h000000AB, 1'b1, 4'd2},  // R2
        '{1'b0, 12'h200, 32'h10000001, 8'd0,   1'b0, 32'h00000010, 1'b1, 4'd3},  // R3
        '{1'b0, 12'h000, 32'hDEADBEEF, 8'd0,   1'b1, 32'hDEADBEEF, 1'b1, 4'd3},  // R3
        '{1'b0, 12'hF80, 32'h00000003, 8'd0,   1'b0, 32'h80000000, 1'b1, 4'd3},  // R3
        '{1'b0, 12'h220, 32'h00000018, 8'd0,   1'b0, 32'h00000001, 1'b1, 4'd4},  // R4
        '{1'b0, 12'h020, 32'h80000000, 8'd0,   1'b0, 32'h00000000, 1'b1, 4'd4},  // R4
        '{1'b0, 12'hFA0, 32'hC0000000, 8'd0,   1'b0, 32'h00000001, 1'b1, 4'd4},  // R4
        '{1'b0, 12'h240, 32'h80000000, 8'd0,   1'b1, 32'hF8000000, 1'b0, 4'd5},  // R5
        '{1'b0, 12'h040, 32'h7FFFFFFF, 8'd0,   1'b1, 32'h00000000, 1'b0, 4'd5},  // R5
        '{1'b0, 12'h040, 32'h80000001, 8'd0,   1'b0, 32'hFFFFFFFF, 1'b1, 4'd5},  // R5
        '{1'b0, 12'h260, 32'h0000000F, 8'd0,   1'b0, 32'hF0000000, 1'b1, 4'd6},  // R6
        '{1'b0, 12'h060, 32'h00000003, 8'd0,   1'b1, 32'h80000001, 1'b1, 4'd6},  // R6
        '{1'b0, 12'h060, 32'h00000002, 8'd0,   1'b0, 32'h00000001, 1'b0, 4'd6},  // R6
        '{1'b0, 12'h010, 32'h12345678, 8'd0,   1'b1, 32'h12345678, 1'b1, 4'd7},  // R7
        '{1'b0, 12'h070, 32'hFFFFFFFF, 8'd0,   1'b0, 32'hFFFFFFFF, 1'b0, 4'd7},  // R7
        '{1'b0, 12'h010, 32'h00000001, 8'd32,  1'b0, 32'h00000000, 1'b1, 4'd8},  // R8
        '{1'b0, 12'h030, 32'h80000000, 8'd32,  1'b0, 32'h00000000, 1'b1, 4'd8},  // R8
        '{1'b0, 12'h010, 32'hFFFFFFFF, 8'd33,  1'b1, 32'h00000000, 1'b0, 4'd8},  // R8
        '{1'b0, 12'h030, 32'hFFFFFFFF, 8'd200, 1'b1, 32'h00000000, 1'b0, 4'd8},  // R8
        '{1'b0, 12'h010, 32'h00000003, 8'd31,  1'b0, 32'h80000000, 1'b1, 4'd8},  // R8
        '{1'b0, 12'h050, 32'h80000000, 8'd40,  1'b0, 32'hFFFFFFFF, 1'b1, 4'd9},  // R9
        '{1'b0, 12'h050, 32'h40000000, 8'd32,  1'b1, 32'h00000000, 1'b0, 4'd9},  // R9
        '{1'b0, 12'h050, 32'h80000003, 8'd1,   1'b0, 32'hC0000001, 1'b1, 4'd9},  // R9
        '{1'b0, 12'h070, 32'h0000000F, 8'd36,  1'b0, 32'hF0000000, 1'b1, 4'd10}, // R10
        '{1'b0, 12'h070, 32'h80000000, 8'd64,  1'b0, 32'h80000000, 1'b1, 4'd10}, // R10
        '{1'b0, 12'h070, 32'h7FFFFFFF, 8'd32,  1'b1, 32'h7FFFFFFF, 1'b0, 4'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        imm_sel;
    logic [11:0] field;
    logic [31:0] rm_val;
    logic [7:0]  rs_byte;
    logic        carry_in;
    logic        out_valid;
    logic [31:0] op2;
    logic        carry_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    operand_shifter u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .imm_sel   (imm_sel),
        .field     (field),
        .rm_val    (rm_val),
        .rs_byte   (rs_byte),
        .carry_in  (carry_in),
        .out_valid (out_valid),
        .op2       (op2),
        .carry_out (carry_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, strobe for one rising edge, return at the next falling edge
    task automatic apply(input logic imm, input logic [11:0] ins, input logic [31:0] rm,
                         input logic [7:0] rs, input logic ci);
        imm_sel  = imm;
        field    = ins;
        rm_val   = rm;
        rs_byte  = rs;
        carry_in = ci;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; imm_sel = 1'b0; field = '0;
        rm_val = '0; rs_byte = '0; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 out_valid in reset", 32'(out_valid), 32'd0);
        chk("R12 op2 in reset", op2, 32'd0);
        chk("R12 carry in reset", 32'(carry_out), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VT[i].imm, VT[i].ins, VT[i].rm, VT[i].rs, VT[i].ci);
            chk($sformatf("R%0d vec %0d value", VT[i].req, i), op2, VT[i].eo);
            chk($sformatf("R%0d vec %0d carry", VT[i].req, i), 32'(carry_out), 32'(VT[i].ec));
            chk($sformatf("R11 vec %0d out_valid", i), 32'(out_valid), 32'd1);
        end

        // R11: changed inputs without the strobe leave the outputs as they were (last vector)
        imm_sel = 1'b1; field = 12'h0FF; carry_in = 1'b1;
        @(negedge clk);
        chk("R11 hold value", op2, 32'h7FFFFFFF);
        chk("R11 hold carry", 32'(carry_out), 32'd0);
        chk("R11 valid low", 32'(out_valid), 32'd0);
        @(negedge clk);
        chk("R11 still held", op2, 32'h7FFFFFFF);

        // R11: back-to-back strobes, each captured
        imm_sel = 1'b1; field = 12'h0FF; carry_in = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        chk("R11 first of pair", op2, 32'h000000FF);
        field = 12'hC03; carry_in = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 second of pair value", op2, 32'h00000300);
        chk("R2 second of pair carry", 32'(carry_out), 32'd0);
        chk("R11 valid on pair", 32'(out_valid), 32'd1);

        // R12: reset after activity clears the stage
        apply(1'b1, 12'h2FF, 32'h0, 8'd0, 1'b0);
        chk("R1 rotate by 4", op2, 32'hF000000F);
        chk("R2 rotate by 4 carry", 32'(carry_out), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R12 op2 after reset", op2, 32'd0);
        chk("R12 carry after reset", 32'(carry_out), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule